// File: doc/BRIEF.md
# Quad 8-bit Open-Drain GPIO Ports

This block gives an 8051-style core four 8-bit general-purpose ports that it reaches through its special-function-register (SFR) space. Each port has three registers. The first is a data/direction latch: a 0 pulls the pin low, and a 1 releases it so that it works as an input. The second enables the pull-up resistors and the third enables the pull-down resistors. The output stage is open-drain only, so a pin cannot be driven high. A high level comes from the pull-up or from the external circuit.

The pull-up bit and pull-down bit of a pin together choose one of four pin modes: floating, pull-down, pull-up or keeper. In keeper mode the block records the pin's synchronized level on the clock edge where the mode begins. It then presents that level to the pad keeper until the mode is left.

Reads follow the usual 8051 convention. A read that the core flags as read-modify-write (bit set, bit clear, OR/XOR, increment and similar operations) returns the latch. Any other read of a port address returns the pin levels, taken through a two-flop synchronizer.

Top module: `gpio_quad_od`

## Requirements
- R1: After reset, every port latch holds 0xFF. Every pull-up and pull-down register holds 0x00. No pad output (low-drive, pull-up, pull-down or keeper enable) is asserted.
- R2: The port latches are at SFR addresses 0x80, 0x90, 0xA0 and 0xB0, for ports 0 to 3. The pull-down registers are at 0xE3 to 0xE6 and the pull-up registers at 0xEB to 0xEE, in port order. A write takes effect on the rising clock edge where `sfr_wr_en` is high.
- R3: Pad bit 8*k+i belongs to pin i of port k. `pad_drive_low` for that bit is high exactly when the corresponding latch bit is 0.
- R4: For each pin, the pair {pull-up bit, pull-down bit} selects the mode. 00 asserts no enable. 01 asserts only `pad_pd_en`. 10 asserts only `pad_pu_en`. 11 asserts only `pad_keep_en`.
- R5: On the edge where a pin enters keeper mode, `pad_keep_val` takes that pin's synchronized level. It holds that value whatever the pin does while the mode lasts. After the mode is left, it follows the synchronized pin level again.
- R6: A read of a port-latch address with `sfr_rmw` high returns the latch contents.
- R7: A read of a port-latch address with `sfr_rmw` low returns the pin levels delayed by two clock edges. A pin change made just after one rising edge shows up after the second rising edge that follows it.
- R8: A read of a pull-up or pull-down register returns its contents, whatever the value of `sfr_rmw`.
- R9: A write to an address outside the twelve registers changes no register and no pad output. A read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wr_en | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rmw | input | 1 | Marks the current read as read-modify-write |
| sfr_rdata | output | 8 | Read data (combinational from address) |
| pad_in | input | 32 | Raw pin levels, bit 8*k+i = port k pin i |
| pad_drive_low | output | 32 | Open-drain pull-low enable per pin |
| pad_pu_en | output | 32 | Pull-up resistor enable per pin |
| pad_pd_en | output | 32 | Pull-down resistor enable per pin |
| pad_keep_en | output | 32 | Keeper enable per pin |
| pad_keep_val | output | 32 | Level the keeper holds per pin |

## Verification
The mode decoder is tested with a single register pair that sets all four bit combinations on different pins of one port. Each enable output is therefore shown to respond to its own code and to no other. Reads of a port are made with the latch and the pins set to different values. This separates the read-modify-write path from the pin path, and sampling one cycle apart shows the two-edge synchronizer delay. For the keeper, the pin changes after keeper mode is entered and changes again after the mode is left. A level that is captured and held can then be told apart from one that keeps tracking the pin. Writes to addresses next to the register ranges test the address decode boundaries.

// File: rtl/gpio_quad_pkg.sv
package gpio_quad_pkg;

  typedef enum logic [1:0] {
    PIN_FLOAT  = 2'b00,
    PIN_PULLDN = 2'b01,
    PIN_PULLUP = 2'b10,
    PIN_KEEP   = 2'b11
  } pin_mode_e;

  // {pull-up, pull-down} -> pin mode
  function automatic pin_mode_e decode_mode(input logic pu, input logic pd);
    return pin_mode_e'({pu, pd});
  endfunction

  function automatic logic [7:0] latch_addr(input int k);
    return 8'(32'h80 + k * 16);
  endfunction

  function automatic logic [7:0] pulldn_addr(input int k);
    return 8'(32'hE3 + k);
  endfunction

  function automatic logic [7:0] pullup_addr(input int k);
    return 8'(32'hEB + k);
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [1:0]   warm_q;   // edges seen since reset, saturates at 2

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      warm_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign pin_sync = stage2_q;

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (pin_sync == $past(pin_in, 2))); // R7

endmodule

// File: rtl/gpio_sfr_regs.sv
module gpio_sfr_regs
  import gpio_quad_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  localparam int PADS     = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wdata,
  input  logic              rmw,
  input  logic [PADS-1:0]   pin_sync,
  output logic [PORT_W-1:0] rdata,
  output logic [PADS-1:0]   latch_flat,
  output logic [PADS-1:0]   pu_flat,
  output logic [PADS-1:0]   pd_flat
);

  logic [NUM_PORTS-1:0] hit_latch;
  logic [NUM_PORTS-1:0] hit_pu;
  logic [NUM_PORTS-1:0] hit_pd;
  logic                 addr_mapped;

  logic [PORT_W-1:0] latch_r [NUM_PORTS];
  logic [PORT_W-1:0] pu_r    [NUM_PORTS];
  logic [PORT_W-1:0] pd_r    [NUM_PORTS];

  assign addr_mapped = |{hit_latch, hit_pu, hit_pd};

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    assign hit_latch[k] = (addr == latch_addr(k));
    assign hit_pu[k]    = (addr == pullup_addr(k));
    assign hit_pd[k]    = (addr == pulldn_addr(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_r[k] <= '1;
        pu_r[k]    <= '0;
        pd_r[k]    <= '0;
      end else if (wr_en) begin
        if (hit_latch[k]) latch_r[k] <= wdata;
        if (hit_pu[k])    pu_r[k]    <= wdata;
        if (hit_pd[k])    pd_r[k]    <= wdata;
      end
    end

    assign latch_flat[k*PORT_W +: PORT_W] = latch_r[k];
    assign pu_flat[k*PORT_W +: PORT_W]    = pu_r[k];
    assign pd_flat[k*PORT_W +: PORT_W]    = pd_r[k];

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_latch[k]) |=> (latch_r[k] == $past(wdata))); // R2
    AST_RMW_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rmw && hit_latch[k]) |-> (rdata == latch_r[k])); // R6
    AST_PIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!rmw && hit_latch[k]) |-> (rdata == pin_sync[k*PORT_W +: PORT_W])); // R7
    AST_PULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pu[k] |-> (rdata == pu_r[k])); // R8
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (hit_latch[k]) rdata = rmw ? latch_r[k] : pin_sync[k*PORT_W +: PORT_W];
      if (hit_pu[k])    rdata = pu_r[k];
      if (hit_pd[k])    rdata = pd_r[k];
    end
  end

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (rdata == '0)); // R9
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_mapped) |=> ($stable(latch_flat) && $stable(pu_flat) && $stable(pd_flat))); // R9

endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode
  import gpio_quad_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pu_bits,
  input  logic [W-1:0] pd_bits,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pu_en,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] keep_en,
  output logic [W-1:0] keep_val
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_mode_e mode;
    logic      hold_q;

    assign mode       = decode_mode(pu_bits[i], pd_bits[i]);
    assign pu_en[i]   = (mode == PIN_PULLUP);
    assign pd_en[i]   = (mode == PIN_PULLDN);
    assign keep_en[i] = (mode == PIN_KEEP);

    // Tracks the pin while not keeping; freezes from the entry edge on.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold_q <= 1'b0;
      else if (!keep_en[i]) hold_q <= pin_sync[i];
    end

    assign keep_val[i] = hold_q;

    AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      keep_en[i] |=> (!keep_en[i] || $stable(keep_val[i]))); // R5
  end

endmodule

// File: rtl/gpio_quad_od.sv
module gpio_quad_od #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  localparam int PADS     = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr_en,
  input  logic [PORT_W-1:0] sfr_wdata,
  input  logic              sfr_rmw,
  output logic [PORT_W-1:0] sfr_rdata,
  input  logic [PADS-1:0]   pad_in,
  output logic [PADS-1:0]   pad_drive_low,
  output logic [PADS-1:0]   pad_pu_en,
  output logic [PADS-1:0]   pad_pd_en,
  output logic [PADS-1:0]   pad_keep_en,
  output logic [PADS-1:0]   pad_keep_val
);

  logic [PADS-1:0] pin_sync;
  logic [PADS-1:0] latch_flat;
  logic [PADS-1:0] pu_flat;
  logic [PADS-1:0] pd_flat;

  gpio_pin_sync #(.W(PADS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_sfr_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (sfr_addr),
    .wr_en      (sfr_wr_en),
    .wdata      (sfr_wdata),
    .rmw        (sfr_rmw),
    .pin_sync   (pin_sync),
    .rdata      (sfr_rdata),
    .latch_flat (latch_flat),
    .pu_flat    (pu_flat),
    .pd_flat    (pd_flat)
  );

  gpio_pin_mode #(.W(PADS)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .pu_bits  (pu_flat),
    .pd_bits  (pd_flat),
    .pin_sync (pin_sync),
    .pu_en    (pad_pu_en),
    .pd_en    (pad_pd_en),
    .keep_en  (pad_keep_en),
    .keep_val (pad_keep_val)
  );

  // Open-drain: a cleared latch bit pulls the pad low, a set bit releases it.
  assign pad_drive_low = ~latch_flat;

  AST_KEEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_keep_en & (pad_pu_en | pad_pd_en)) == '0)); // R4
  AST_PULLS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu_en & pad_pd_en) == '0)); // R4

endmodule

// File: tb/gpio_quad_od_tb.sv
`timescale 1ns/1ps
module gpio_quad_od_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr_en = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic        sfr_rmw = 1'b0;
  logic [7:0]  sfr_rdata;
  logic [31:0] pad_in = 32'h0;
  logic [31:0] pad_drive_low, pad_pu_en, pad_pd_en, pad_keep_en, pad_keep_val;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_quad_od u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en),
    .sfr_wdata(sfr_wdata), .sfr_rmw(sfr_rmw), .sfr_rdata(sfr_rdata),
    .pad_in(pad_in), .pad_drive_low(pad_drive_low), .pad_pu_en(pad_pu_en),
    .pad_pd_en(pad_pd_en), .pad_keep_en(pad_keep_en), .pad_keep_val(pad_keep_val)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr_en = 1'b1;
    @(negedge clk);
    sfr_wr_en = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, input bit rmw, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_rmw = rmw;
    #1 d = sfr_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      sfr_read(8'(8'h80 + k*16), 1'b1, d);
      check(d == 8'hFF, "R1 latch reset", 32'(d), 32'hFF);
      sfr_read(8'(8'hE3 + k), 1'b0, d);
      check(d == 8'h00, "R1 pull-down reset", 32'(d), 32'h0);
      sfr_read(8'(8'hEB + k), 1'b0, d);
      check(d == 8'h00, "R1 pull-up reset", 32'(d), 32'h0);
    end
    check(pad_drive_low == 0, "R1 drive_low reset", pad_drive_low, 0);
    check((pad_pu_en | pad_pd_en | pad_keep_en) == 0, "R1 enables reset",
          pad_pu_en | pad_pd_en | pad_keep_en, 0);
  endtask

  task automatic t_write_map();
    logic [7:0] d;
    // write timing: not visible before the edge
    @(negedge clk);
    sfr_addr = 8'h80; sfr_wdata = 8'h12; sfr_rmw = 1'b1; sfr_wr_en = 1'b1;
    #1 check(sfr_rdata == 8'hFF, "R2 write before edge", 32'(sfr_rdata), 32'hFF);
    @(negedge clk);
    sfr_wr_en = 1'b0;
    #1 check(sfr_rdata == 8'h12, "R2 write after edge", 32'(sfr_rdata), 32'h12);
    sfr_write(8'h90, 8'h34);
    sfr_write(8'hA0, 8'h56);
    sfr_write(8'hB0, 8'h78);
    for (int k = 0; k < 4; k++) begin
      sfr_read(8'(8'h80 + k*16), 1'b1, d);
      check(d == 8'(8'h12 + k*8'h22), "R2 R6 latch map", 32'(d), 32'(8'h12 + k*8'h22));
    end
    check(pad_drive_low == ~32'h78563412, "R3 drive_low inverse", pad_drive_low, ~32'h78563412);
    for (int k = 0; k < 4; k++) sfr_write(8'(8'hE3 + k), 8'(8'h11 * (k+1)));
    for (int k = 0; k < 4; k++) begin
      sfr_read(8'(8'hE3 + k), 1'b1, d);
      check(d == 8'(8'h11 * (k+1)), "R8 pull-down readback rmw", 32'(d), 32'(8'h11 * (k+1)));
      sfr_read(8'(8'hE3 + k), 1'b0, d);
      check(d == 8'(8'h11 * (k+1)), "R8 pull-down readback", 32'(d), 32'(8'h11 * (k+1)));
    end
    check(pad_pd_en == 32'h44332211, "R2 R4 pull-down pins", pad_pd_en, 32'h44332211);
    sfr_write(8'hEE, 8'hA5);
    sfr_read(8'hEE, 1'b0, d);
    check(d == 8'hA5, "R8 pull-up port3 readback", 32'(d), 32'hA5);
    for (int k = 0; k < 4; k++) sfr_write(8'(8'hE3 + k), 8'h00);
    sfr_write(8'hEE, 8'h00);
  endtask

  task automatic t_modes();
    sfr_write(8'hEB, 8'hF0);
    sfr_write(8'hE3, 8'hCC);
    check(pad_pu_en[7:0] == 8'h30, "R4 pull-up only for 10", 32'(pad_pu_en[7:0]), 32'h30);
    check(pad_pd_en[7:0] == 8'h0C, "R4 pull-down only for 01", 32'(pad_pd_en[7:0]), 32'h0C);
    check(pad_keep_en[7:0] == 8'hC0, "R4 keeper only for 11", 32'(pad_keep_en[7:0]), 32'hC0);
    check(pad_keep_en[31:8] == 0, "R4 other ports unaffected", pad_keep_en, 32'hC0);
    sfr_write(8'hEB, 8'h00);
    sfr_write(8'hE3, 8'h00);
  endtask

  task automatic t_keep();
    logic [7:0] d;
    @(negedge clk); pad_in[7:0] = 8'hA5;
    repeat (4) @(negedge clk);
    sfr_write(8'hEB, 8'hFF);
    sfr_write(8'hE3, 8'hFF);
    check(pad_keep_en[7:0] == 8'hFF, "R5 keeper entered", 32'(pad_keep_en[7:0]), 32'hFF);
    check(pad_keep_val[7:0] == 8'hA5, "R5 captured level", 32'(pad_keep_val[7:0]), 32'hA5);
    check((pad_pu_en[7:0] | pad_pd_en[7:0]) == 0, "R4 pulls off in keep",
          32'(pad_pu_en[7:0] | pad_pd_en[7:0]), 0);
    pad_in[7:0] = 8'h5A;
    repeat (4) @(negedge clk);
    check(pad_keep_val[7:0] == 8'hA5, "R5 held while pin changes", 32'(pad_keep_val[7:0]), 32'hA5);
    sfr_read(8'h80, 1'b0, d);
    check(d == 8'h5A, "R7 pin read during keep", 32'(d), 32'h5A);
    sfr_write(8'hE3, 8'h00);
    check(pad_pu_en[7:0] == 8'hFF, "R4 back to pull-up", 32'(pad_pu_en[7:0]), 32'hFF);
    repeat (2) @(negedge clk);
    check(pad_keep_val[7:0] == 8'h5A, "R5 tracks after leaving", 32'(pad_keep_val[7:0]), 32'h5A);
    sfr_write(8'hEB, 8'h00);
  endtask

  task automatic t_pin_read();
    logic [7:0] d;
    sfr_write(8'h90, 8'h0F);
    @(negedge clk);
    pad_in[15:8] = 8'hC3; sfr_addr = 8'h90; sfr_rmw = 1'b0;
    @(negedge clk);
    #1 check(sfr_rdata == 8'h00, "R7 one edge: old level", 32'(sfr_rdata), 32'h00);
    @(negedge clk);
    #1 check(sfr_rdata == 8'hC3, "R7 two edges: new level", 32'(sfr_rdata), 32'hC3);
    sfr_read(8'h90, 1'b1, d);
    check(d == 8'h0F, "R6 rmw returns latch not pins", 32'(d), 32'h0F);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [31:0] dl;
    dl = pad_drive_low;
    sfr_write(8'h81, 8'h00);
    sfr_write(8'hE2, 8'hFF);
    sfr_write(8'hE7, 8'hFF);
    sfr_write(8'hEA, 8'hFF);
    sfr_write(8'hEF, 8'hFF);
    check(pad_drive_low == dl, "R9 latches untouched", pad_drive_low, dl);
    check((pad_pu_en | pad_pd_en | pad_keep_en) == 0, "R9 pulls untouched",
          pad_pu_en | pad_pd_en | pad_keep_en, 0);
    sfr_read(8'h81, 1'b1, d);
    check(d == 8'h00, "R9 read 0x81", 32'(d), 0);
    sfr_read(8'hE7, 1'b0, d);
    check(d == 8'h00, "R9 read 0xE7", 32'(d), 0);
    sfr_read(8'hEF, 1'b0, d);
    check(d == 8'h00, "R9 read 0xEF", 32'(d), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_map();
    t_modes();
    t_keep();
    t_pin_read();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule